// File: doc/BRIEF.md
# Approximate Unsigned Multiplier with OR-Merged Partial-Product Rows

This block multiplies two 8-bit unsigned operands and returns a 16-bit product that is slightly smaller than the exact one. The partial-product matrix is produced in full with AND gates. Each pair of neighbouring rows is then merged into a single row across a band of low columns: each aligned bit pair in the band is replaced by its OR. The band gets narrower as the row pair moves up in significance, so the upper product bits are left untouched. The surviving bits are then packed by weight into a matrix of half the original height, and an exact carry-save chain with one final carry-propagate adder sums them.

The block suits datapaths that tolerate a small, always downward error in exchange for a shorter accumulation path. An optional output register captures the product when the input is valid and flags the result valid one cycle later.

Top module: `amul_sdlc`

## Requirements
- R1: Partial product bit (i, j) is a_i[j] & b_i[i] with weight i+j. Whenever no merged column holds two ones, the product is exactly a_i*b_i. Examples: 0*255 = 0, 1*255 = 255, 128*255 = 32640.
- R2: Row pair k (rows 2k and 2k+1, k = 0..3) merges its L = 7-k lowest overlapping columns, at weights 2k+1 through 2k+L. At weight w the merged bit is (a_i[w-2k] & b_i[2k]) | (a_i[w-2k-1] & b_i[2k+1]).
- R3: A merged column whose two bits are both 1 loses exactly 2^w. The product equals a_i*b_i minus the sum of these losses, so 3*3 gives 7.
- R4: Bits outside every merged band are summed exactly with full carry propagation. These are the lowest bit of row 2k, the top bit of row 2k+1, and both bits of each overlap column above the band. Example: 192*255 gives 48960-128 = 48832.
- R5: The product never exceeds a_i*b_i, and the shortfall never exceeds 3670, which is the sum of the weights of all merged columns.
- R6: The result is a 16-bit unsigned value that matches R3 for every one of the 65536 operand pairs, including 255*255.
- R7: With REG_OUT=1, out_valid_o equals in_valid_i from the previous rising edge. product_o loads only on an edge where in_valid_i is 1 and holds its value otherwise.
- R8: While rst_ni is low, product_o and out_valid_o are 0, taking effect immediately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operands valid |
| a_i | input | 8 | Multiplicand |
| b_i | input | 8 | Multiplier |
| product_o | output | 16 | Approximate product |
| out_valid_o | output | 1 | Product valid |

## Verification
Two things can happen on the same clock edge: the output register loads a new product while the previous product is still being read, and a hold starts when in_valid_i falls. The bench drives operands on every cycle without a gap, so each new capture replaces a product that was checked one cycle earlier. It then drops in_valid_i at the same time as it changes the operands, and requires the last product to stay frozen. Every product is compared with a loss-subtraction model computed from R3, and an asynchronous reset in the middle of the run must clear a live, nonzero product immediately.

// File: rtl/amul_pkg.sv
package amul_pkg;

  function automatic int clu_len(int n, int k);
    return n - 1 - k;
  endfunction

  // rows 0..n/2-1: merged rows; rows n/2..n-1: leftover upper-row bits
  function automatic bit slot_used(int n, int r, int w);
    int k;
    int l;
    if (r < n / 2) begin
      k = r;
      return (w >= 2 * k) && (w <= 2 * k + n);
    end
    k = r - n / 2;
    l = clu_len(n, k);
    return (w > 2 * k + l) && (w <= 2 * k + n - 1);
  endfunction

  function automatic int col_height(int n, int w);
    int cnt;
    cnt = 0;
    for (int r = 0; r < n; r++) if (slot_used(n, r, w)) cnt++;
    return cnt;
  endfunction

  function automatic int max_height(int n);
    int m;
    m = 1;
    for (int w = 0; w < 2 * n; w++) if (col_height(n, w) > m) m = col_height(n, w);
    return m;
  endfunction

  // source row of the j-th occupied slot in column w, -1 if none
  function automatic int pack_src(int n, int j, int w);
    int cnt;
    cnt = 0;
    for (int r = 0; r < n; r++) begin
      if (slot_used(n, r, w)) begin
        if (cnt == j) return r;
        cnt++;
      end
    end
    return -1;
  endfunction

  function automatic int max_deficit(int n);
    int s;
    s = 0;
    for (int k = 0; k < n / 2; k++)
      for (int w = 2 * k + 1; w <= 2 * k + clu_len(n, k); w++) s += (1 << w);
    return s;
  endfunction

endpackage

// File: rtl/amul_pp_gen.sv
module amul_pp_gen #(
  parameter int N = 8
) (
  input  logic [N-1:0]         a_i,
  input  logic [N-1:0]         b_i,
  output logic [N-1:0][N-1:0]  pp_o
);
  for (genvar i = 0; i < N; i++) begin : g_row
    for (genvar j = 0; j < N; j++) begin : g_bit
      assign pp_o[i][j] = a_i[j] & b_i[i];
    end
  end
endmodule

// File: rtl/amul_or_cluster.sv
module amul_or_cluster #(
  parameter int N = 8,
  parameter int K = 0,
  localparam int W = 2 * N
) (
  input  logic [N-1:0] row_lo_i,
  input  logic [N-1:0] row_hi_i,
  output logic [W-1:0] merged_o,
  output logic [W-1:0] resid_o
);
  localparam int BASE = 2 * K;
  localparam int L    = amul_pkg::clu_len(N, K);

  for (genvar w = 0; w < W; w++) begin : g_col
    if (w == BASE) begin : g_lsb
      assign merged_o[w] = row_lo_i[0];
      assign resid_o[w]  = 1'b0;
    end else if (w > BASE && w <= BASE + L) begin : g_or
      assign merged_o[w] = row_lo_i[w-BASE] | row_hi_i[w-BASE-1];
      assign resid_o[w]  = 1'b0;
    end else if (w > BASE + L && w <= BASE + N - 1) begin : g_keep
      assign merged_o[w] = row_lo_i[w-BASE];
      assign resid_o[w]  = row_hi_i[w-BASE-1];
    end else if (w == BASE + N) begin : g_msb
      assign merged_o[w] = row_hi_i[N-1];
      assign resid_o[w]  = 1'b0;
    end else begin : g_none
      assign merged_o[w] = 1'b0;
      assign resid_o[w]  = 1'b0;
    end
  end
endmodule

// File: rtl/amul_col_pack.sv
module amul_col_pack #(
  parameter int N = 8,
  localparam int W = 2 * N,
  localparam int OUT_ROWS = amul_pkg::max_height(N)
) (
  input  logic [N-1:0][W-1:0]        rows_i,
  output logic [OUT_ROWS-1:0][W-1:0] rows_o
);
  // static regroup: occupied slots of each column slide to the lowest rows
  for (genvar j = 0; j < OUT_ROWS; j++) begin : g_row
    for (genvar w = 0; w < W; w++) begin : g_col
      localparam int SRC = amul_pkg::pack_src(N, j, w);
      if (SRC >= 0) begin : g_map
        assign rows_o[j][w] = rows_i[SRC][w];
      end else begin : g_zero
        assign rows_o[j][w] = 1'b0;
      end
    end
  end
endmodule

// File: rtl/amul_csa_sum.sv
module amul_csa_sum #(
  parameter int ROWS = 4,
  parameter int W    = 16
) (
  input  logic [ROWS-1:0][W-1:0] rows_i,
  output logic [W-1:0]           sum_o
);
  if (ROWS == 1) begin : g_one
    assign sum_o = rows_i[0];
  end else if (ROWS == 2) begin : g_two
    assign sum_o = rows_i[0] + rows_i[1];
  end else begin : g_chain
    logic [ROWS-1:1][W-1:0] s;
    logic [ROWS-1:1][W-1:0] c;
    assign s[1] = rows_i[0];
    assign c[1] = rows_i[1];
    for (genvar i = 2; i < ROWS; i++) begin : g_csa
      assign s[i] = s[i-1] ^ c[i-1] ^ rows_i[i];
      assign c[i] = ((s[i-1] & c[i-1]) | (s[i-1] & rows_i[i]) | (c[i-1] & rows_i[i])) << 1;
    end
    assign sum_o = s[ROWS-1] + c[ROWS-1];
  end
endmodule

// File: rtl/amul_sdlc.sv
module amul_sdlc #(
  parameter int N       = 8,
  parameter bit REG_OUT = 1'b1,
  localparam int W = 2 * N
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         in_valid_i,
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  output logic [W-1:0] product_o,
  output logic         out_valid_o
);
  localparam int PAIRS    = N / 2;
  localparam int OUT_ROWS = amul_pkg::max_height(N);

  logic [N-1:0][N-1:0]        pp;
  logic [N-1:0][W-1:0]        mat;
  logic [OUT_ROWS-1:0][W-1:0] packed_rows;
  logic [W-1:0]               sum;

  amul_pp_gen #(.N(N)) u_pp (
    .a_i  (a_i),
    .b_i  (b_i),
    .pp_o (pp)
  );

  for (genvar k = 0; k < PAIRS; k++) begin : g_clu
    amul_or_cluster #(.N(N), .K(k)) u_clu (
      .row_lo_i (pp[2*k]),
      .row_hi_i (pp[2*k+1]),
      .merged_o (mat[k]),
      .resid_o  (mat[PAIRS+k])
    );
  end

  amul_col_pack #(.N(N)) u_pack (
    .rows_i (mat),
    .rows_o (packed_rows)
  );

  amul_csa_sum #(.ROWS(OUT_ROWS), .W(W)) u_sum (
    .rows_i (packed_rows),
    .sum_o  (sum)
  );

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        product_o   <= '0;
        out_valid_o <= 1'b0;
      end else begin
        out_valid_o <= in_valid_i;
        if (in_valid_i) product_o <= sum;
      end
    end
  end else begin : g_comb
    assign product_o   = sum;
    assign out_valid_o = in_valid_i;
  end
endmodule

// File: rtl/amul_sdlc_chk.sv
module amul_sdlc_chk #(
  parameter int N       = 8,
  parameter bit REG_OUT = 1'b1,
  localparam int W = 2 * N
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         in_valid_i,
  input logic [N-1:0] a_i,
  input logic [N-1:0] b_i,
  input logic [W-1:0] product_o,
  input logic         out_valid_o
);
  localparam int MAX_DEF = amul_pkg::max_deficit(N);

  logic [W-1:0] exact_now;
  assign exact_now = {{N{1'b0}}, a_i} * {{N{1'b0}}, b_i};

  if (REG_OUT) begin : g_reg
    logic         started;
    logic [W-1:0] exact_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        started <= 1'b0;
        exact_q <= '0;
      end else begin
        started <= 1'b1;
        exact_q <= exact_now;
      end
    end

    a_r7_valid_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
      started |-> out_valid_o == $past(in_valid_i));
    a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      started && !$past(in_valid_i) |-> $stable(product_o));
    a_r5_not_above: assert property (@(posedge clk_i) disable iff (!rst_ni)
      started && $past(in_valid_i) |-> product_o <= exact_q);
    a_r5_err_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
      started && $past(in_valid_i) |-> (int'(exact_q) - int'(product_o)) <= MAX_DEF);
    a_r1_zero_operand: assert property (@(posedge clk_i) disable iff (!rst_ni)
      started && $past(in_valid_i) && exact_q == '0 |-> product_o == '0);
  end else begin : g_comb
    a_r5_not_above: assert property (@(posedge clk_i) disable iff (!rst_ni)
      in_valid_i |-> product_o <= exact_now);
    a_r5_err_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
      in_valid_i |-> (int'(exact_now) - int'(product_o)) <= MAX_DEF);
    a_r1_zero_operand: assert property (@(posedge clk_i) disable iff (!rst_ni)
      in_valid_i && exact_now == '0 |-> product_o == '0);
    a_r7_valid_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_valid_o == in_valid_i);
  end
endmodule

bind amul_sdlc amul_sdlc_chk #(.N(N), .REG_OUT(REG_OUT)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .a_i         (a_i),
  .b_i         (b_i),
  .product_o   (product_o),
  .out_valid_o (out_valid_o)
);

// File: tb/amul_sdlc_tb.sv
`timescale 1ns/1ps
module amul_sdlc_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic [7:0]  a_i = '0;
  logic [7:0]  b_i = '0;
  logic [15:0] product_o;
  logic        out_valid_o;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk_i = ~clk_i;

  amul_sdlc u_dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .a_i         (a_i),
    .b_i         (b_i),
    .product_o   (product_o),
    .out_valid_o (out_valid_o)
  );

  // {a, b}
  localparam logic [15:0] VEC [12] = '{
    16'h0000, 16'hFF00, 16'h00FF, 16'h0303, 16'hFFFF, 16'h5555,
    16'hAAAA, 16'h0F0F, 16'hF0F0, 16'h8181, 16'h7E3C, 16'hC3A5
  };

  // exact product minus 2^w for each merged column holding two ones
  function automatic logic [15:0] ref_prod(logic [7:0] a, logic [7:0] b);
    int e;
    e = int'(a) * int'(b);
    for (int k = 0; k < 4; k++)
      for (int w = 2 * k + 1; w <= 2 * k + 7 - k; w++)
        if (a[w-2*k] && b[2*k] && a[w-2*k-1] && b[2*k+1]) e -= (1 << w);
    return 16'(e);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
  endtask

  task automatic apply(input logic [7:0] a, input logic [7:0] b);
    @(negedge clk_i);
    a_i = a;
    b_i = b;
    in_valid_i = 1'b1;
    @(negedge clk_i);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
    summary();
    $finish;
  end

  initial begin
    logic [15:0] held;
    longint      err_sum;
    int          err_max;
    int          d;

    repeat (3) @(negedge clk_i);
    check(product_o == 16'd0, "R8 reset product", product_o, 0);
    check(out_valid_o == 1'b0, "R8 reset valid", out_valid_o, 0);
    rst_ni = 1'b1;

    // R1 R3 R4 directed, literal expectations
    apply(8'd0, 8'd255);
    check(product_o == 16'd0, "R1 zero operand", product_o, 0);
    check(out_valid_o == 1'b1, "R7 valid one cycle later", out_valid_o, 1);
    apply(8'd1, 8'd255);
    check(product_o == 16'd255, "R1 exact 1*255", product_o, 255);
    apply(8'd128, 8'd255);
    check(product_o == 16'd32640, "R1 exact 128*255", product_o, 32640);
    apply(8'd3, 8'd3);
    check(product_o == 16'd7, "R3 both-ones loss 3*3", product_o, 7);
    apply(8'd192, 8'd255);
    check(product_o == 16'd48832, "R4 uncovered exact 192*255", product_o, 48832);

    // R2 R6 table, back-to-back valid
    foreach (VEC[i]) begin
      apply(VEC[i][15:8], VEC[i][7:0]);
      check(product_o == ref_prod(VEC[i][15:8], VEC[i][7:0]), "R2 table vector",
            product_o, ref_prod(VEC[i][15:8], VEC[i][7:0]));
      check(product_o <= 16'(int'(VEC[i][15:8]) * int'(VEC[i][7:0])), "R5 not above exact",
            product_o, int'(VEC[i][15:8]) * int'(VEC[i][7:0]));
    end

    // R7 hold while in_valid_i low with changed operands
    held = product_o;
    @(negedge clk_i);
    in_valid_i = 1'b0;
    a_i = 8'd99;
    b_i = 8'd77;
    @(negedge clk_i);
    check(product_o == held, "R7 hold product", product_o, held);
    check(out_valid_o == 1'b0, "R7 valid drops", out_valid_o, 0);
    @(negedge clk_i);
    check(product_o == held, "R7 hold second cycle", product_o, held);

    // R8 asynchronous reset of a live nonzero product
    apply(8'd200, 8'd201);
    check(product_o == ref_prod(8'd200, 8'd201), "R6 live product", product_o,
          ref_prod(8'd200, 8'd201));
    #1 rst_ni = 1'b0;
    #1;
    check(product_o == 16'd0, "R8 async clear product", product_o, 0);
    check(out_valid_o == 1'b0, "R8 async clear valid", out_valid_o, 0);
    @(negedge clk_i);
    in_valid_i = 1'b0;
    rst_ni = 1'b1;

    // R6 exhaustive, R5 error statistics
    err_sum = 0;
    err_max = 0;
    for (int ia = 0; ia < 256; ia++) begin
      for (int ib = 0; ib < 256; ib++) begin
        apply(8'(ia), 8'(ib));
        check(product_o == ref_prod(8'(ia), 8'(ib)), "R6 exhaustive", product_o,
              ref_prod(8'(ia), 8'(ib)));
        d = ia * ib - int'(product_o);
        if (d < 0 || d > 3670) check(1'b0, "R5 error range", d, 3670);
        err_sum += longint'(d);
        if (d > err_max) err_max = d;
      end
    end
    check(err_max <= 3670, "R5 max shortfall", err_max, 3670);
    $display("mean error %f, max error %0d", real'(err_sum) / 65536.0, err_max);

    summary();
    $finish;
  end
endmodule